// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block runs on the host side of a NOR flash bus after a program or erase command has already been written. It reads status words from the flash repeatedly. From those words it decides whether the embedded operation has finished, is still in progress, or has failed. Two detection methods can be picked for each run. The first is complement polling, which compares the completion bit of each status word against the true data bit. The second is toggle polling, which compares the toggle bit across two back-to-back reads.

Reads are issued through a plain request/acknowledge port. Every read goes to the address latched at start. That address must be a valid one: the programmed location, or any unprotected sector for a chip erase. The error bit only triggers a recheck, which guards against the moment when the status bits settle on the same read as the error bit rises. A per-run read limit turns a stuck part into a timeout result. In erase mode the target word is all ones.

Top module: `flash_poll_engine`

## Requirements
- R1: After reset, and after a reset applied during a run, `busy_o`, `rd_req_o`, `done_o`, `pass_o`, `fail_o` and `timeout_o` are all 0.
- R2: Every read request goes to the address latched at the accepted start. `rd_req_o` stays high, with a stable address, until `rd_ack_i` is sampled high.
- R3: In complement mode (`mode_i`=0), a read whose bit 7 equals bit 7 of the target ends the run. In program mode (`erase_i`=0) that run passes.
- R4: In complement mode, a read whose bit 7 differs from the target while bit 5 is 1 causes exactly one more read. That read passes if its bit 7 matches the target and fails if it does not.
- R5: In toggle mode (`mode_i`=1), the first read only primes the comparison. A later read whose bit 6 equals bit 6 of the read before it ends the run, and in program mode that run passes.
- R6: In toggle mode, a read whose bit 6 differs from the previous read while bit 5 is 1 causes two further reads. If their bit 6 values differ, the run fails; if they are equal, the run completes.
- R7: With `erase_i`=1 the target is all ones. A run that reaches completion passes only if the completing word is all ones, and fails otherwise.
- R8: If a read brings no decision and the read count has reached `max_reads_i`, the run ends with `timeout_o`=1. A decision reached on the final permitted read takes precedence over the timeout.
- R9: A start pulse while `busy_o` is high has no effect on the address, the mode or the outcome of the run in progress.
- R10: When `done_o` is 1, exactly one of `pass_o`, `fail_o` and `timeout_o` is 1. The result appears one clock after the acknowledge of the deciding read, is held until the next accepted start, and is cleared by that start.
- R11: `read_count_o` counts the reads acknowledged in the current run. A new start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| mode_i | input | 1 | 0 = complement polling, 1 = toggle polling |
| erase_i | input | 1 | 1 = erase run (target all ones) |
| addr_i | input | AW | Status read address |
| exp_data_i | input | DW | True data for a program run |
| max_reads_i | input | CW | Read limit for the run |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | DW | Read data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Result valid |
| pass_o | output | 1 | Operation completed correctly |
| fail_o | output | 1 | Operation reported failure |
| timeout_o | output | 1 | Read limit reached without a decision |
| read_count_o | output | CW | Reads acknowledged in this run |

## Verification
A read acknowledged at clock edge A is captured at that edge and judged on the next cycle. So the verdict flags settle after edge A+1, and when the run continues, the next request is raised at that same edge. The bench stamps the cycle of every acknowledge it returns and the cycle in which `done_o` is first seen. It requires a gap of exactly two counter steps between them. It samples all outputs on the falling edge. The read count is compared against the exact number of words the bench model returned for the chosen pattern.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_EVAL} fsm_e;
  typedef enum logic [2:0] {PH_PRIME, PH_RUN, PH_RECHK, PH_RE1, PH_RE2} phase_e;
  typedef enum logic [1:0] {VD_CONT, VD_PASS, VD_FAIL} verdict_e;
endpackage

// File: rtl/poll_bus_port.sv
module poll_bus_port #(
  parameter int AW = 22,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic          issue_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [DW-1:0] word_o,
  output logic [CW-1:0] count_o
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] word_q;
  logic [CW-1:0] cnt_q;
  logic          beat;

  assign beat = issue_i & rd_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      word_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (launch_i) begin
        addr_q <= addr_i;
        cnt_q  <= '0;
      end else if (beat) begin
        word_q <= rd_data_i;
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign rd_req_o  = issue_i;
  assign rd_addr_o = addr_q;
  assign word_o    = word_q;
  assign count_o   = cnt_q;
endmodule

// File: rtl/poll_judge.sv
module poll_judge
  import flash_poll_pkg::*;
#(
  parameter int DW       = 16,
  parameter int DONE_BIT = 7,
  parameter int TGL_BIT  = 6,
  parameter int ERR_BIT  = 5
) (
  input  logic          toggle_i,
  input  logic          erase_i,
  input  logic [DW-1:0] exp_i,
  input  logic [DW-1:0] cur_i,
  input  logic [DW-1:0] prev_i,
  input  phase_e        phase_i,
  output verdict_e      verdict_o,
  output phase_e        phase_o,
  output logic          load_prev_o
);
  logic [DW-1:0] target;
  logic          dq_match, tg_same, err_bit;
  verdict_e      finish;

  assign target   = erase_i ? '1 : exp_i;
  assign dq_match = (cur_i[DONE_BIT] == target[DONE_BIT]);
  assign tg_same  = (cur_i[TGL_BIT] == prev_i[TGL_BIT]);
  assign err_bit  = cur_i[ERR_BIT];
  // erase completion requires the whole word to read as all ones
  assign finish   = (erase_i && (cur_i != {DW{1'b1}})) ? VD_FAIL : VD_PASS;

  always_comb begin
    verdict_o   = VD_CONT;
    phase_o     = phase_i;
    load_prev_o = 1'b0;
    if (!toggle_i) begin
      unique case (phase_i)
        PH_RECHK: verdict_o = dq_match ? finish : VD_FAIL;
        default: begin
          if (dq_match)     verdict_o = finish;
          else if (err_bit) phase_o   = PH_RECHK;
        end
      endcase
    end else begin
      load_prev_o = 1'b1;
      unique case (phase_i)
        PH_PRIME: phase_o = PH_RUN;
        PH_RE1:   phase_o = PH_RE2;
        PH_RE2:   verdict_o = tg_same ? finish : VD_FAIL;
        default: begin
          if (tg_same)      verdict_o = finish;
          else if (err_bit) phase_o   = PH_RE1;
        end
      endcase
    end
  end
endmodule

// File: rtl/poll_limit.sv
module poll_limit #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic [CW-1:0] max_i,
  input  logic [CW-1:0] count_i,
  output logic          at_limit_o
);
  logic [CW-1:0] max_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       max_q <= '0;
    else if (launch_i) max_q <= max_i;
  end

  assign at_limit_o = (count_i >= max_q);
endmodule

// File: rtl/flash_poll_engine.sv
module flash_poll_engine
  import flash_poll_pkg::*;
#(
  parameter int AW       = 22,
  parameter int DW       = 16,
  parameter int CW       = 8,
  parameter int DONE_BIT = 7,
  parameter int TGL_BIT  = 6,
  parameter int ERR_BIT  = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic          erase_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] exp_data_i,
  input  logic [CW-1:0] max_reads_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic          fail_o,
  output logic          timeout_o,
  output logic [CW-1:0] read_count_o
);
  fsm_e          state_q;
  phase_e        phase_q, phase_nx;
  verdict_e      verdict;
  logic          toggle_q, erase_q, load_prev, at_limit, launch;
  logic [DW-1:0] exp_q, prev_q, cur_word;
  logic [CW-1:0] count;
  logic          done_q, pass_q, fail_q, tmo_q;

  assign launch = (state_q == ST_IDLE) && start_i;

  poll_bus_port #(.AW(AW), .DW(DW), .CW(CW)) u_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch),
    .issue_i   (state_q == ST_REQ),
    .addr_i    (addr_i),
    .rd_ack_i  (rd_ack_i),
    .rd_data_i (rd_data_i),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .word_o    (cur_word),
    .count_o   (count)
  );

  poll_judge #(.DW(DW), .DONE_BIT(DONE_BIT), .TGL_BIT(TGL_BIT), .ERR_BIT(ERR_BIT)) u_judge (
    .toggle_i    (toggle_q),
    .erase_i     (erase_q),
    .exp_i       (exp_q),
    .cur_i       (cur_word),
    .prev_i      (prev_q),
    .phase_i     (phase_q),
    .verdict_o   (verdict),
    .phase_o     (phase_nx),
    .load_prev_o (load_prev)
  );

  poll_limit #(.CW(CW)) u_limit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .launch_i   (launch),
    .max_i      (max_reads_i),
    .count_i    (count),
    .at_limit_o (at_limit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      phase_q  <= PH_RUN;
      toggle_q <= 1'b0;
      erase_q  <= 1'b0;
      exp_q    <= '0;
      prev_q   <= '0;
      done_q   <= 1'b0;
      pass_q   <= 1'b0;
      fail_q   <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q  <= ST_REQ;
          toggle_q <= mode_i;
          erase_q  <= erase_i;
          exp_q    <= exp_data_i;
          phase_q  <= mode_i ? PH_PRIME : PH_RUN;
          done_q   <= 1'b0;
          pass_q   <= 1'b0;
          fail_q   <= 1'b0;
          tmo_q    <= 1'b0;
        end
        ST_REQ: if (rd_ack_i) state_q <= ST_EVAL;
        ST_EVAL: begin
          if (load_prev) prev_q <= cur_word;
          phase_q <= phase_nx;
          if (verdict != VD_CONT) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            pass_q  <= (verdict == VD_PASS);
            fail_q  <= (verdict == VD_FAIL);
          end else if (at_limit) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            tmo_q   <= 1'b1;
          end else begin
            state_q <= ST_REQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign pass_o       = pass_q;
  assign fail_o       = fail_q;
  assign timeout_o    = tmo_q;
  assign read_count_o = count;
endmodule

// File: rtl/flash_poll_engine_chk.sv
module flash_poll_engine_chk #(
  parameter int AW = 22,
  parameter int CW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_ack_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          pass_o,
  input logic          fail_o,
  input logic          timeout_o,
  input logic [CW-1:0] read_count_o
);
  assert_req_only_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> busy_o);

  assert_req_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));

  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(rd_addr_o));

  assert_one_result_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones({pass_o, fail_o, timeout_o}) == 1);

  assert_result_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(rd_ack_i, 2) && !busy_o);

  assert_count_step_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_ack_i |=> read_count_o == CW'($past(read_count_o) + 1'b1));
endmodule

bind flash_poll_engine flash_poll_engine_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .rd_req_o     (rd_req_o),
  .rd_addr_o    (rd_addr_o),
  .rd_ack_i     (rd_ack_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .pass_o       (pass_o),
  .fail_o       (fail_o),
  .timeout_o    (timeout_o),
  .read_count_o (read_count_o)
);

// File: tb/tb_flash_poll_engine.sv
module tb_flash_poll_engine;
  localparam int AW = 22;
  localparam int DW = 16;
  localparam int CW = 8;

  typedef struct packed {
    logic             mode;
    logic             erase;
    logic [DW-1:0]    exp;
    logic [CW-1:0]    maxr;
    logic [2:0]       n;
    logic [3:0][15:0] w;
    logic [1:0]       res;   // 1 pass, 2 fail, 3 timeout
    logic [7:0]       reads;
  } vec_t;

  function automatic vec_t mk(input logic m, input logic e, input logic [15:0] x,
                              input logic [7:0] mr, input logic [2:0] n,
                              input logic [15:0] a, input logic [15:0] b,
                              input logic [15:0] c, input logic [15:0] d,
                              input logic [1:0] r, input logic [7:0] rd);
    vec_t v;
    v.mode = m; v.erase = e; v.exp = x; v.maxr = mr; v.n = n;
    v.w = {d, c, b, a}; v.res = r; v.reads = rd;
    return v;
  endfunction

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    mk(1'b0, 1'b0, 16'h00A5, 8'd20, 3'd1, 16'h00A5, 16'h0, 16'h0, 16'h0, 2'd1, 8'd1), // R3
    mk(1'b0, 1'b0, 16'h00A5, 8'd20, 3'd3, 16'h0000, 16'h0040, 16'h00A5, 16'h0, 2'd1, 8'd3), // R3
    mk(1'b0, 1'b0, 16'h00A5, 8'd20, 3'd2, 16'h0020, 16'h00A5, 16'h0, 16'h0, 2'd1, 8'd2), // R4
    mk(1'b0, 1'b0, 16'h00A5, 8'd20, 3'd2, 16'h0020, 16'h0020, 16'h0, 16'h0, 2'd2, 8'd2), // R4
    mk(1'b0, 1'b1, 16'h0000, 8'd20, 3'd2, 16'h0000, 16'hFFFF, 16'h0, 16'h0, 2'd1, 8'd2), // R7
    mk(1'b0, 1'b1, 16'h0000, 8'd20, 3'd1, 16'h0080, 16'h0, 16'h0, 16'h0, 2'd2, 8'd1), // R7
    mk(1'b1, 1'b0, 16'h00A5, 8'd20, 3'd4, 16'h0040, 16'h0000, 16'h0040, 16'h0040, 2'd1, 8'd4), // R5
    mk(1'b1, 1'b0, 16'h00A5, 8'd20, 3'd4, 16'h0000, 16'h0060, 16'h0000, 16'h0000, 2'd1, 8'd4), // R6
    mk(1'b1, 1'b0, 16'h00A5, 8'd20, 3'd4, 16'h0000, 16'h0060, 16'h0000, 16'h0040, 2'd2, 8'd4), // R6
    mk(1'b1, 1'b1, 16'h0000, 8'd20, 3'd4, 16'h0000, 16'h0040, 16'hFFFF, 16'hFFFF, 2'd1, 8'd3), // R7
    mk(1'b1, 1'b1, 16'h0000, 8'd20, 3'd2, 16'h0044, 16'h0044, 16'h0, 16'h0, 2'd2, 8'd2), // R7
    mk(1'b0, 1'b0, 16'h00A5, 8'd5,  3'd1, 16'h0000, 16'h0, 16'h0, 16'h0, 2'd3, 8'd5), // R8
    mk(1'b1, 1'b0, 16'h00A5, 8'd4,  3'd2, 16'h0000, 16'h0040, 16'h0, 16'h0, 2'd3, 8'd4), // R8
    mk(1'b0, 1'b0, 16'h00A5, 8'd3,  3'd3, 16'h0000, 16'h0040, 16'h00A5, 16'h0, 2'd1, 8'd3)  // R8
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          mode_i = 1'b0;
  logic          erase_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] exp_data_i = '0;
  logic [CW-1:0] max_reads_i = '0;
  logic          rd_req_o;
  logic [AW-1:0] rd_addr_o;
  logic          rd_ack_i = 1'b0;
  logic [DW-1:0] rd_data_i = '0;
  logic          busy_o, done_o, pass_o, fail_o, timeout_o;
  logic [CW-1:0] read_count_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_ack = 0;
  int k = 0;
  int nwords = 1;
  logic [3:0][15:0] words = '0;
  logic [AW-1:0] exp_addr = '0;
  logic addr_bad = 1'b0;

  always #4 clk_i = ~clk_i;

  flash_poll_engine #(.AW(AW), .DW(DW), .CW(CW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .erase_i(erase_i), .addr_i(addr_i), .exp_data_i(exp_data_i),
    .max_reads_i(max_reads_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .busy_o(busy_o),
    .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o),
    .timeout_o(timeout_o), .read_count_o(read_count_o)
  );

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (rd_req_o && rd_ack_i) last_ack <= cyc;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // flash model: answers each request at the falling edge
  initial begin
    forever begin
      @(negedge clk_i);
      if (rd_ack_i) rd_ack_i = 1'b0;
      else if (rd_req_o && rst_ni) begin
        if (rd_addr_o !== exp_addr) addr_bad = 1'b1;
        rd_data_i = words[k % nwords];
        k++;
        rd_ack_i = 1'b1;
      end
    end
  end

  task automatic launch(input vec_t v, input logic [AW-1:0] a);
    @(negedge clk_i);
    mode_i = v.mode; erase_i = v.erase; exp_data_i = v.exp;
    max_reads_i = v.maxr; addr_i = a; exp_addr = a;
    words = v.w; nwords = int'(v.n); k = 0; addr_bad = 1'b0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int t = 0; t < 200 && !done_o; t++) @(negedge clk_i);
  endtask

  task automatic judge(input vec_t v, input string req);
    logic [2:0] flags;
    flags = {pass_o, fail_o, timeout_o};
    check({req, " done"}, done_o, 1'b1);
    check({req, " result"}, flags, v.res == 2'd1 ? 3'b100 : v.res == 2'd2 ? 3'b010 : 3'b001);
    check({"R11 ", req, " count"}, read_count_o, v.reads);
    check({"R10 ", req, " latency"}, cyc - last_ack, 2);
    check({"R2 ", req, " addr"}, addr_bad, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset outputs", {busy_o, rd_req_o, done_o, pass_o, fail_o, timeout_o}, 6'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle after release", {busy_o, rd_req_o, done_o}, 3'b0);

    for (int i = 0; i < NV; i++) begin
      launch(VECS[i], AW'(22'h1000 + i));
      wait_done();
      judge(VECS[i], $sformatf("vec%0d", i));
    end

    // R10: result held, then cleared by next accepted start
    repeat (5) @(negedge clk_i);
    check("R10 result held", {done_o, pass_o}, 2'b11);
    launch(VECS[11], AW'(22'h2222));
    check("R10 cleared by start", {done_o, pass_o, fail_o, timeout_o}, 4'b0);
    check("R11 count cleared", read_count_o, 0);

    // R9: start while busy, with other settings, must not disturb the run
    mode_i = 1'b1; erase_i = 1'b1; addr_i = AW'(22'h3333); max_reads_i = 8'd1;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done();
    check("R9 outcome kept", {pass_o, fail_o, timeout_o}, 3'b001);
    check("R9 count kept", read_count_o, 5);
    check("R9 addr kept", addr_bad, 1'b0);
    check("R9 addr port", rd_addr_o, 22'h2222);

    // R1: reset during a run
    launch(VECS[11], AW'(22'h4444));
    repeat (2) @(negedge clk_i);
    check("R1 busy before reset", busy_o, 1'b1);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 mid-run reset", {busy_o, rd_req_o, done_o, pass_o, fail_o, timeout_o}, 6'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule